// File: doc/BRIEF.md
# Shared External Bus Arbitration Controller

This block lets two bus masters share one external bus through three active-low handshake pins. The pins are a request pin (called HOLD), an acknowledge pin (called HLDA) and a bus-request-back pin (called BREQ). A single instance can play either role. In master role it owns the bus and hands it over when asked. In slave role it starts without the bus and asks for it. The direction of each pin depends on the role. This lets a master-role instance and a slave-role instance be wired pin to pin with nothing in between.

Software controls the block with an enable bit and a role bit. While the enable bit is clear, the handshake pins are not driven, their inputs are ignored, and the local bus drivers stay active. Once enabled, the block watches a "bus cycle in progress" flag from the local bus sequencer, so a transfer is never cut in half. It watches an "access pending" flag so that it can request the bus back. It reports through `bus_released` whether the local bus drivers must be tri-stated. Every handshake input passes through a synchroniser chain of parameterised length, at least two flops, before any state machine uses it.

Each pin is modelled as a separate input, output value and output enable, so that pin multiplexing can be placed around the block.

Top module: `bus_share_arbiter`

## Requirements
- R1: While `arb_en` is 0, `bus_released` is 0, all three `*_oe` outputs are 0, and changes on `hold_i`, `hlda_i` and `breq_i` have no effect on these outputs.
- R2: After reset with `arb_en` low, `bus_released` is 0, all `*_oe` are 0, and `hold_o`, `hlda_o` and `breq_o` are 1 (the inactive level; all pins are active low).
- R3: With `arb_en`=1 and `slave_mode`=0 (master role), `hlda_oe`=1, `breq_oe`=1 and `hold_oe`=0. With `arb_en`=1 and `slave_mode`=1 (slave role), `hold_oe`=1, `hlda_oe`=0 and `breq_oe`=0.
- R4: In master role, the block grants a low `hold_i` only while `cycle_busy` is 0. When `cycle_busy` is already 0, `bus_released` goes to 1 and `hlda_o` goes to 0 on the third rising edge after `hold_i` falls, and not earlier.
- R5: In master role, while the bus is granted away, `breq_o` is 0 exactly when `access_pending` is 1. At all other times in master role, `breq_o` is 1.
- R6: In master role, once `hold_i` returns high, `hlda_o` goes to 1 on the third rising edge while `bus_released` stays 1. On the fourth rising edge, `bus_released` returns to 0.
- R7: In slave role, the block starts with `bus_released`=1. It drives `hold_o` low one edge after `access_pending` is seen. It keeps `bus_released` at 1 until a low `hlda_i` has passed the synchroniser, which takes three rising edges.
- R8: In slave role, while the bus is owned, a low `breq_i` makes the block set `bus_released` to 1 and `hold_o` to 1, but only once `cycle_busy` is 0. It does not request again until `hlda_i` has been seen high.
- R9: A master-role instance and a slave-role instance, wired pin to pin, never both drive the bus. Each one gets the bus under competing traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_en | input | 1 | Arbitration enable (software) |
| slave_mode | input | 1 | 0 = master role, 1 = slave role |
| cycle_busy | input | 1 | Local bus cycle in progress |
| access_pending | input | 1 | Local access waiting for the bus |
| hold_i | input | 1 | HOLD pin input value |
| hold_o | output | 1 | HOLD pin output value |
| hold_oe | output | 1 | HOLD pin output enable |
| hlda_i | input | 1 | HLDA pin input value |
| hlda_o | output | 1 | HLDA pin output value |
| hlda_oe | output | 1 | HLDA pin output enable |
| breq_i | input | 1 | BREQ pin input value |
| breq_o | output | 1 | BREQ pin output value |
| breq_oe | output | 1 | BREQ pin output enable |
| bus_released | output | 1 | 1 = local bus drivers tri-stated |

## Verification
The bench goes after each edge of the synchroniser latency. A design that skipped a flop would release the bus one edge early. A design that added a flop would release it one edge late. Both faults show up at the cycle-exact checks of grant and reclaim. It holds `cycle_busy` high across a HOLD or BREQ request, where a careless design would tear down a transfer in progress. It also leaves HLDA stale-low after a slave gives up the bus, where a careless slave would request again at once and could overlap with the master. Finally, it wires a master-role instance to a slave-role instance and drives them with random traffic. A handshake with a wrong direction or ordering would show up there as both sides driving the bus, or as one side never getting it.

// File: rtl/bus_share_arbiter_pkg.sv
package bus_share_arbiter_pkg;

   typedef enum logic [1:0] {
      M_OWN     = 2'd0,
      M_GRANT   = 2'd1,
      M_RECLAIM = 2'd2
   } mst_state_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_REQ  = 2'd1,
      S_OWN  = 2'd2
   } slv_state_e;

   typedef struct packed {
      logic hold;
      logic hlda;
      logic breq;
   } hs_bits_t;

   localparam int HS_W = $bits(hs_bits_t);

   function automatic logic to_pin(input logic act, input bit active_low);
      return active_low ? ~act : act;
   endfunction

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
   parameter int         WIDTH    = 3,
   parameter int         STAGES   = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("arb_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_badw
         $error("arb_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[s] <= RST_VAL;
            end else if (s == 0) begin
               chain[s] <= d;
            end else begin
               chain[s] <= chain[(s > 0) ? s-1 : 0];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/arb_master_fsm.sv
module arb_master_fsm
   import bus_share_arbiter_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic hold_act,
   input  logic cycle_busy,
   input  logic access_pending,
   output logic released,
   output logic hlda_act,
   output logic breq_act
);
   mst_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         M_OWN:     if (hold_act && !cycle_busy) state_d = M_GRANT;
         M_GRANT:   if (!hold_act)               state_d = M_RECLAIM;
         M_RECLAIM:                              state_d = M_OWN;
         default:                                state_d = M_OWN;
      endcase
      if (!run) state_d = M_OWN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= M_OWN;
      else        state_q <= state_d;
   end

   assign released = (state_q != M_OWN);
   assign hlda_act = (state_q == M_GRANT);
   assign breq_act = (state_q == M_GRANT) && access_pending;

   // R4: the bus is handed over only between bus cycles
   assert_grant_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $rose(released)) |-> $past(!cycle_busy && hold_act));

   // R6: acknowledge is withdrawn a cycle before the bus is driven again
   assert_hlda_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $fell(released)) |-> $past(!hlda_act));

   // R5: a request back is only raised while the bus is away
   assert_breq_only_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      breq_act |-> released);
endmodule

// File: rtl/arb_slave_fsm.sv
module arb_slave_fsm
   import bus_share_arbiter_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic hlda_act,
   input  logic breq_act,
   input  logic cycle_busy,
   input  logic access_pending,
   output logic released,
   output logic hold_act
);
   slv_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:  if (access_pending && !hlda_act) state_d = S_REQ;
         S_REQ:   if (hlda_act)                    state_d = S_OWN;
         S_OWN:   if (breq_act && !cycle_busy)     state_d = S_IDLE;
         default:                                  state_d = S_IDLE;
      endcase
      if (!run) state_d = S_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= S_IDLE;
      else        state_q <= state_d;
   end

   assign released = (state_q != S_OWN);
   assign hold_act = (state_q == S_REQ) || (state_q == S_OWN);

   // R7: the bus is only driven after the acknowledge was seen
   assert_own_after_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $fell(released)) |-> $past(hlda_act));

   // R8: the bus is given back only between bus cycles
   assert_drop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $rose(released)) |-> $past(!cycle_busy && breq_act));

   // R8: no new request while the old acknowledge is still active
   assert_no_stale_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $rose(hold_act)) |-> $past(!hlda_act));
endmodule

// File: rtl/bus_share_arbiter.sv
module bus_share_arbiter
   import bus_share_arbiter_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit ACTIVE_LOW  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arb_en,
   input  logic slave_mode,
   input  logic cycle_busy,
   input  logic access_pending,
   input  logic hold_i,
   output logic hold_o,
   output logic hold_oe,
   input  logic hlda_i,
   output logic hlda_o,
   output logic hlda_oe,
   input  logic breq_i,
   output logic breq_o,
   output logic breq_oe,
   output logic bus_released
);
   localparam logic [HS_W-1:0] IDLE_LEVEL = ACTIVE_LOW ? '1 : '0;

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("bus_share_arbiter: SYNC_STAGES below 2 is not safe");
      end
   endgenerate

   hs_bits_t pin_raw, pin_sync, act;
   logic     run_m, run_s;
   logic     m_rel, m_hlda, m_breq;
   logic     s_rel, s_hold;

   assign pin_raw = '{hold: hold_i, hlda: hlda_i, breq: breq_i};

   arb_sync #(
      .WIDTH   (HS_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IDLE_LEVEL)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_raw),
      .q     (pin_sync)
   );

   generate
      if (ACTIVE_LOW) begin : g_pol_low
         assign act = ~pin_sync;
      end else begin : g_pol_high
         assign act = pin_sync;
      end
   endgenerate

   assign run_m = arb_en && !slave_mode;
   assign run_s = arb_en &&  slave_mode;

   arb_master_fsm u_mst (
      .clk            (clk),
      .rst_n          (rst_n),
      .run            (run_m),
      .hold_act       (act.hold),
      .cycle_busy     (cycle_busy),
      .access_pending (access_pending),
      .released       (m_rel),
      .hlda_act       (m_hlda),
      .breq_act       (m_breq)
   );

   arb_slave_fsm u_slv (
      .clk            (clk),
      .rst_n          (rst_n),
      .run            (run_s),
      .hlda_act       (act.hlda),
      .breq_act       (act.breq),
      .cycle_busy     (cycle_busy),
      .access_pending (access_pending),
      .released       (s_rel),
      .hold_act       (s_hold)
   );

   assign hold_oe = run_s;
   assign hlda_oe = run_m;
   assign breq_oe = run_m;

   assign hold_o = to_pin(run_s && s_hold, ACTIVE_LOW);
   assign hlda_o = to_pin(run_m && m_hlda, ACTIVE_LOW);
   assign breq_o = to_pin(run_m && m_breq, ACTIVE_LOW);

   always_comb begin
      if (run_m)      bus_released = m_rel;
      else if (run_s) bus_released = s_rel;
      else            bus_released = 1'b0;
   end

   // R1: disabled means owned, with every pin left undriven
   assert_disabled_owned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !arb_en |-> (!bus_released && !hold_oe && !hlda_oe && !breq_oe));

   // R3: exactly one direction set per role
   assert_pin_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      arb_en |-> (hlda_oe != hold_oe) && (breq_oe == hlda_oe));

   // R4: acknowledge is active only while the bus is floated
   assert_ack_implies_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hlda_oe && (hlda_o == to_pin(1'b1, ACTIVE_LOW))) |-> bus_released);
endmodule

// File: tb/bus_share_arbiter_tb.sv
module bus_share_arbiter_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic en, smode, busy, pend, hold_i, hlda_i, breq_i;
   logic hold_o, hold_oe, hlda_o, hlda_oe, breq_o, breq_oe, rel;

   bus_share_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .arb_en(en), .slave_mode(smode),
      .cycle_busy(busy), .access_pending(pend),
      .hold_i(hold_i), .hold_o(hold_o), .hold_oe(hold_oe),
      .hlda_i(hlda_i), .hlda_o(hlda_o), .hlda_oe(hlda_oe),
      .breq_i(breq_i), .breq_o(breq_o), .breq_oe(breq_oe),
      .bus_released(rel)
   );

   // pair of instances wired pin to pin with pull-ups
   logic p_en, m_busy, m_pend, s_busy, s_pend;
   logic m_hold_o, m_hold_oe, m_hlda_o, m_hlda_oe, m_breq_o, m_breq_oe, m_rel;
   logic s_hold_o, s_hold_oe, s_hlda_o, s_hlda_oe, s_breq_o, s_breq_oe, s_rel;
   logic w_hold, w_hlda, w_breq;
   assign w_hold = s_hold_oe ? s_hold_o : (m_hold_oe ? m_hold_o : 1'b1);
   assign w_hlda = m_hlda_oe ? m_hlda_o : (s_hlda_oe ? s_hlda_o : 1'b1);
   assign w_breq = m_breq_oe ? m_breq_o : (s_breq_oe ? s_breq_o : 1'b1);

   bus_share_arbiter u_peer_m (
      .clk(clk), .rst_n(rst_n), .arb_en(p_en), .slave_mode(1'b0),
      .cycle_busy(m_busy), .access_pending(m_pend),
      .hold_i(w_hold), .hold_o(m_hold_o), .hold_oe(m_hold_oe),
      .hlda_i(w_hlda), .hlda_o(m_hlda_o), .hlda_oe(m_hlda_oe),
      .breq_i(w_breq), .breq_o(m_breq_o), .breq_oe(m_breq_oe),
      .bus_released(m_rel)
   );
   bus_share_arbiter u_peer_s (
      .clk(clk), .rst_n(rst_n), .arb_en(p_en), .slave_mode(1'b1),
      .cycle_busy(s_busy), .access_pending(s_pend),
      .hold_i(w_hold), .hold_o(s_hold_o), .hold_oe(s_hold_oe),
      .hlda_i(w_hlda), .hlda_o(s_hlda_o), .hlda_oe(s_hlda_oe),
      .breq_i(w_breq), .breq_o(s_breq_o), .breq_oe(s_breq_oe),
      .bus_released(s_rel)
   );

   // expected output enables {hold, hlda, breq} from the requirements
   function automatic logic [2:0] exp_oe(input logic e, input logic s);
      if (!e)     return 3'b000;
      else if (s) return 3'b100;
      else        return 3'b011;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      int both_own, s_owned, m_back;
      en = 0; smode = 0; busy = 0; pend = 0; hold_i = 1; hlda_i = 1; breq_i = 1;
      p_en = 0; m_busy = 0; m_pend = 0; s_busy = 0; s_pend = 0;
      seed = $urandom(32'd1234);
      step(3);
      rst_n = 1'b1;
      step(1);

      // R2 reset state
      chk("R2 released", rel, 0);
      chk("R2 oe", {hold_oe, hlda_oe, breq_oe}, 0);
      chk("R2 pin levels", {hold_o, hlda_o, breq_o}, 3'b111);

      // R1 disabled ignores pins
      hold_i = 0; hlda_i = 0; breq_i = 0;
      step(6);
      chk("R1 released", rel, 0);
      chk("R1 oe", {hold_oe, hlda_oe, breq_oe}, exp_oe(en, smode));
      hold_i = 1; hlda_i = 1; breq_i = 1;
      step(4);

      // R3 master directions
      en = 1; smode = 0;
      step(1);
      chk("R3 master oe", {hold_oe, hlda_oe, breq_oe}, exp_oe(en, smode));
      chk("R5 breq idle owned", breq_o, 1);

      // R4 hold during a bus cycle
      busy = 1; hold_i = 0;
      step(6);
      chk("R4 held during cycle", rel, 0);
      busy = 0;
      step(1);
      chk("R4 granted after cycle", {rel, hlda_o}, 2'b10);

      // R5 request back
      pend = 0; step(1);
      chk("R5 breq no pending", breq_o, 1);
      pend = 1; step(1);
      chk("R5 breq pending", breq_o, 0);

      // R6 reclaim order
      hold_i = 1;
      step(2);
      chk("R6 hlda before sync", {rel, hlda_o}, 2'b10);
      step(1);
      chk("R6 hlda first", {rel, hlda_o}, 2'b11);
      step(1);
      chk("R6 bus retaken", rel, 0);
      chk("R5 breq after reclaim", breq_o, 1);
      pend = 0;

      // R4 exact latency
      step(2);
      hold_i = 0;
      step(1); chk("R4 edge1", rel, 0);
      step(1); chk("R4 edge2", rel, 0);
      step(1); chk("R4 edge3", {rel, hlda_o}, 2'b10);
      hold_i = 1;
      step(5);
      chk("R6 settled", rel, 0);

      // R3/R7 slave role
      en = 0; step(1);
      smode = 1; en = 1; step(1);
      chk("R3 slave oe", {hold_oe, hlda_oe, breq_oe}, exp_oe(en, smode));
      chk("R7 starts released", {rel, hold_o}, 2'b11);
      pend = 1; step(1);
      chk("R7 hold asserted", hold_o, 0);
      step(5);
      chk("R7 no grant yet", rel, 1);
      hlda_i = 0;
      step(2); chk("R7 before sync", rel, 1);
      step(1); chk("R7 owns after hlda", rel, 0);

      // R8 release on breq
      busy = 1; breq_i = 0;
      step(5);
      chk("R8 held during cycle", rel, 0);
      busy = 0;
      step(1);
      chk("R8 released", {rel, hold_o}, 2'b11);
      breq_i = 1;
      step(6);
      chk("R8 no request on stale hlda", hold_o, 1);
      hlda_i = 1;
      step(2); chk("R8 before sync", hold_o, 1);
      step(1); chk("R8 new request", hold_o, 0);

      // R1 disabled in slave role
      hlda_i = 0;
      en = 0; step(4);
      chk("R1 slave disabled", {rel, hold_oe, hlda_oe, breq_oe}, 0);
      hlda_i = 1; pend = 0;

      // R9 pair under random traffic
      p_en = 1;
      both_own = 0; s_owned = 0; m_back = 0;
      for (int c = 0; c < 4000; c++) begin
         m_busy = ($urandom % 4) == 0;
         s_busy = ($urandom % 4) == 0;
         m_pend = ($urandom % 3) != 0;
         s_pend = ($urandom % 3) != 0;
         @(posedge clk);
         @(negedge clk);
         if (!m_rel && !s_rel) both_own++;
         if (!s_rel) s_owned++;
         if (!m_rel) m_back++;
      end
      chk("R9 never both own", both_own[7:0] | {7'd0, both_own != 0}, 0);
      chk("R9 slave got bus", s_owned > 0, 1);
      chk("R9 master got bus", m_back > 0, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule